// File: doc/BRIEF.md
# QoS Read/Write Bus Direction Selector

This block chooses which way a memory controller's shared data bus should point next, toward reads or toward writes. The controller keeps one read queue and one write queue for each of several quality-of-service levels. The block receives the occupancy count of every one of those queues. The highest level that holds any request makes the choice. All lower levels are ignored.

If that deciding level has only reads pending, the bus goes to READ. If it has only writes pending, the bus goes to WRITE. If it has both, the bus swaps to the direction it is not currently in, so that neither side starves. If nothing is pending anywhere, the bus keeps its direction.

The current direction is held in a register that changes only on a cycle with the decision strobe high. A one-cycle flag marks each update that reversed the bus. The deciding level and a flag saying that any level has work are produced combinationally from the counts in the same cycle. The controller can therefore see which level would win before it strobes.

Top module: `qos_bus_turn_sel`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dir_o` is READ and `turn_o` is 0. The encoding is READ = 0 and WRITE = 1.
- R2: The level with the highest index that has a nonzero read or write count decides the choice, and `win_lvl_o` reports that level. Level k's count sits at bits [k*CNT_W +: CNT_W] of each count bus. Counts at lower levels have no effect on `dir_o`.
- R3: A level whose read and write counts are both zero is skipped, even when it is above the deciding level.
- R4: When the deciding level has writes but no reads, a strobed update sets `dir_o` to WRITE.
- R5: When the deciding level has reads but no writes, a strobed update sets `dir_o` to READ.
- R6: When the deciding level has both reads and writes, a strobed update inverts `dir_o`.
- R7: When every count is zero, `valid_o` is 0, `win_lvl_o` is 0, and a strobed update leaves `dir_o` unchanged. Otherwise `valid_o` is 1.
- R8: In a cycle with `decide_i` low, `dir_o` does not change at the next edge.
- R9: `turn_o` is 1 for exactly the cycle after a strobed update that changed `dir_o`, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| decide_i | input | 1 | Strobe that commits the selected direction |
| rd_cnt_i | input | NUM_LVL*CNT_W | Read queue occupancy, one field per level |
| wr_cnt_i | input | NUM_LVL*CNT_W | Write queue occupancy, one field per level |
| dir_o | output | 1 | Registered bus direction (0 = READ, 1 = WRITE) |
| turn_o | output | 1 | One-cycle pulse: the last update reversed the bus |
| valid_o | output | 1 | Some level has pending requests (combinational) |
| win_lvl_o | output | IDX_W | Deciding level index (combinational, 0 when idle) |

## Verification
`valid_o` and `win_lvl_o` depend only on the present counts. The bench therefore checks them one time unit after driving new counts, before the next rising edge. `dir_o` and `turn_o` both come from flops loaded at the strobed edge, so each is due one edge after the stimulus. The bench samples them at the following falling edge, which is also the point where it drives the next vector. A `turn_o` pulse is confirmed to have dropped by the vector that follows it.

// File: rtl/qos_turn_pkg.sv
package qos_turn_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // Summary of the winning level, without its index
    typedef struct packed {
        logic valid;
        logic has_rd;
        logic has_wr;
    } pick_t;

    function automatic dir_e pick_next_dir(pick_t p, dir_e cur);
        dir_e nxt;
        if (!p.valid) begin
            nxt = cur;
        end else if (p.has_rd && p.has_wr) begin
            nxt = (cur == DIR_RD) ? DIR_WR : DIR_RD;
        end else if (p.has_wr) begin
            nxt = DIR_WR;
        end else begin
            nxt = DIR_RD;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/qos_lvl_flags.sv
module qos_lvl_flags #(
    parameter int NUM_LVL = 4,
    parameter int CNT_W   = 4
) (
    input  logic [NUM_LVL*CNT_W-1:0] rd_cnt,
    input  logic [NUM_LVL*CNT_W-1:0] wr_cnt,
    output logic [NUM_LVL-1:0]       rd_busy,
    output logic [NUM_LVL-1:0]       wr_busy
);
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign rd_busy[g] = |rd_cnt[g*CNT_W +: CNT_W];
        assign wr_busy[g] = |wr_cnt[g*CNT_W +: CNT_W];
    end
endmodule

// File: rtl/qos_prio_scan.sv
module qos_prio_scan
    import qos_turn_pkg::*;
#(
    parameter int NUM_LVL = 4,
    localparam int IDX_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic [NUM_LVL-1:0] rd_busy,
    input  logic [NUM_LVL-1:0] wr_busy,
    output pick_t              pick,
    output logic [IDX_W-1:0]   idx
);
    // Ascending walk: the last nonempty level seen is the highest one
    always_comb begin
        pick = '0;
        idx  = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (rd_busy[i] || wr_busy[i]) begin
                pick.valid  = 1'b1;
                pick.has_rd = rd_busy[i];
                pick.has_wr = wr_busy[i];
                idx         = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/qos_dir_reg.sv
module qos_dir_reg
    import qos_turn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  decide,
    input  pick_t pick,
    output dir_e  dir_q,
    output logic  turn_q
);
    dir_e dir_nxt;

    always_comb dir_nxt = pick_next_dir(pick, dir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= DIR_RD;
            turn_q <= 1'b0;
        end else begin
            turn_q <= decide && (dir_nxt != dir_q);
            if (decide) begin
                dir_q <= dir_nxt;
            end
        end
    end
endmodule

// File: rtl/qos_bus_turn_sel.sv
module qos_bus_turn_sel
    import qos_turn_pkg::*;
#(
    parameter int NUM_LVL = 4,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     decide_i,
    input  logic [NUM_LVL*CNT_W-1:0] rd_cnt_i,
    input  logic [NUM_LVL*CNT_W-1:0] wr_cnt_i,
    output logic                     dir_o,
    output logic                     turn_o,
    output logic                     valid_o,
    output logic [IDX_W-1:0]         win_lvl_o
);
    logic [NUM_LVL-1:0] rd_busy;
    logic [NUM_LVL-1:0] wr_busy;
    pick_t              pick;
    logic [IDX_W-1:0]   idx;
    dir_e               dir_q;
    logic               turn_q;

    qos_lvl_flags #(.NUM_LVL(NUM_LVL), .CNT_W(CNT_W)) u_flags (
        .rd_cnt (rd_cnt_i),
        .wr_cnt (wr_cnt_i),
        .rd_busy(rd_busy),
        .wr_busy(wr_busy)
    );

    qos_prio_scan #(.NUM_LVL(NUM_LVL)) u_scan (
        .rd_busy(rd_busy),
        .wr_busy(wr_busy),
        .pick   (pick),
        .idx    (idx)
    );

    qos_dir_reg u_dir (
        .clk   (clk),
        .rst   (rst),
        .decide(decide_i),
        .pick  (pick),
        .dir_q (dir_q),
        .turn_q(turn_q)
    );

    assign dir_o     = dir_q;
    assign turn_o    = turn_q;
    assign valid_o   = pick.valid;
    assign win_lvl_o = idx;

    // R2: the reported level really holds work
    assert_win_busy_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((rd_cnt_i[win_lvl_o*CNT_W +: CNT_W] != '0) ||
                     (wr_cnt_i[win_lvl_o*CNT_W +: CNT_W] != '0)));

    // R7: idle scan reports level zero and keeps the direction
    assert_idle_lvl_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (win_lvl_o == '0));
    assert_idle_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (decide_i && !valid_o) |=> $stable(dir_o));

    // R8: no strobe, no change
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !decide_i |=> $stable(dir_o));

    // R9: a turn pulse always accompanies a direction change
    assert_turn_change_R9: assert property (@(posedge clk) disable iff (rst)
        (decide_i && valid_o && pick.has_rd && pick.has_wr) |=> turn_o);
    assert_turn_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        turn_o |-> (dir_o != $past(dir_o)));

    // R4/R5: single-sided demand sets the matching direction
    assert_wr_only_R4: assert property (@(posedge clk) disable iff (rst)
        (decide_i && valid_o && pick.has_wr && !pick.has_rd) |=> (dir_o == 1'b1));
    assert_rd_only_R5: assert property (@(posedge clk) disable iff (rst)
        (decide_i && valid_o && pick.has_rd && !pick.has_wr) |=> (dir_o == 1'b0));

endmodule

// File: tb/qos_bus_turn_sel_tb.sv
module qos_bus_turn_sel_tb_top;
    localparam int NL = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          decide_i;
    logic [15:0]   rd_cnt_i;
    logic [15:0]   wr_cnt_i;
    logic          dir_o;
    logic          turn_o;
    logic          valid_o;
    logic [1:0]    win_lvl_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5ns clk = ~clk;

    qos_bus_turn_sel #(.NUM_LVL(NL), .CNT_W(CW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .decide_i (decide_i),
        .rd_cnt_i (rd_cnt_i),
        .wr_cnt_i (wr_cnt_i),
        .dir_o    (dir_o),
        .turn_o   (turn_o),
        .valid_o  (valid_o),
        .win_lvl_o(win_lvl_o)
    );

    // {rd[15:0], wr[15:0], decide, exp_dir, exp_turn, exp_valid, exp_lvl[1:0]}
    localparam int NV = 12;
    localparam logic [37:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0}, // R7 idle keeps READ
        {16'h0000, 16'h0003, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0}, // R4 writes only
        {16'h0000, 16'h0003, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0}, // R9 stay, no pulse
        {16'h0500, 16'h0003, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2}, // R2 R5 level 2 wins
        {16'h0010, 16'h0010, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1}, // R6 both -> invert
        {16'h0010, 16'h0010, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1}, // R6 invert back
        {16'h0010, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1}, // R8 no strobe
        {16'h0010, 16'hF010, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3}, // R2 R3 level 3 writes
        {16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0}, // R7 idle keeps WRITE
        {16'h2000, 16'h0700, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3}, // R5 R3 level 3 reads
        {16'h1000, 16'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3}, // R8 held while both
        {16'h1000, 16'h1000, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3}  // R6 strobe inverts
    };

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000us;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    initial begin
        rst = 1'b1;
        decide_i = 1'b0;
        rd_cnt_i = '0;
        wr_cnt_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "dir in reset", dir_o, 0);
        check("R1", "turn in reset", turn_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "dir after reset", dir_o, 0);
        check("R1", "turn after reset", turn_o, 0);

        for (int v = 0; v < NV; v++) begin
            rd_cnt_i = VEC[v][37:22];
            wr_cnt_i = VEC[v][21:6];
            decide_i = VEC[v][5];
            #1ns;
            check("R2/R3/R7", $sformatf("valid v%0d", v), valid_o, int'(VEC[v][2]));
            check("R2/R3/R7", $sformatf("level v%0d", v), win_lvl_o, int'(VEC[v][1:0]));
            @(negedge clk);
            check("R4/R5/R6/R7/R8", $sformatf("dir v%0d", v), dir_o, int'(VEC[v][4]));
            check("R9", $sformatf("turn v%0d", v), turn_o, int'(VEC[v][3]));
        end

        // R9: the pulse lasts one cycle
        decide_i = 1'b0;
        @(negedge clk);
        check("R9", "pulse dropped", turn_o, 0);
        check("R8", "dir held", dir_o, 1);

        // R1: reset mid-run while reads pending at level 0 with a strobe
        rd_cnt_i = 16'h0001;
        wr_cnt_i = 16'h0000;
        decide_i = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R1", "dir after mid reset", dir_o, 0);
        check("R1", "turn after mid reset", turn_o, 0);
        rst = 1'b0;

        // R4 with large counts at level 0 only, higher levels empty (R3)
        rd_cnt_i = 16'h0000;
        wr_cnt_i = 16'h000F;
        decide_i = 1'b1;
        #1ns;
        check("R3", "level with only level 0 busy", win_lvl_o, 0);
        @(negedge clk);
        check("R4", "dir writes at level 0", dir_o, 1);
        check("R9", "turn to write", turn_o, 1);
        decide_i = 1'b0;
        @(negedge clk);

        finished = 1;
        summary();
    end
endmodule